// File: doc/BRIEF.md
# Pipelined NTT Polynomial Multiplier

This block multiplies two polynomials of degree below 512 in the negacyclic ring Z_q[x]/(x^512+1) with q = 12289. Both operands enter as streams of eight coefficients per clock. Each operand passes through its own forward number-theoretic transform. The two transforms run side by side, and their outputs are multiplied coefficient by coefficient. An inverse transform and a final scaling by 512^-1 mod q then produce the ring product. The product leaves as a stream of eight coefficients per clock.

The data path has eight lanes. A coefficient with index i always travels in lane i mod 8. Butterfly stages whose span is eight or more pair coefficients that lie in the same lane. These stages use per-lane delay-feedback buffers. Stages with spans 4, 2 and 1 pair coefficients that lie in different lanes but arrive in the same clock. These stages are purely combinational, followed by a register. The forward transform takes data in natural order and leaves it in bit-reversed order. The inverse transform takes it in that order and returns natural order. Because of this pairing, no data is ever permuted. Every twiddle factor is a power of a primitive 1024-th root of unity, so the negacyclic wrap is handled inside the transforms. The twiddles are held in small ROMs, one per stage, whose contents are computed at elaboration.

A caller raises `start` together with the first operand group, supplies the remaining 63 groups on the following cycles, and later collects 64 product groups.

Top module: `ntt_polymul`

## Requirements
- R1: After reset, `c_vld_o` and `done_o` are low and stay low until a multiplication has been started.
- R2: When `start` is sampled high while the block is idle, the operand groups for t = 0..63 are taken on that cycle and the 63 cycles that follow. Lane k of `a_i`/`b_i` in group t holds coefficient 8t+k. The same lane and group mapping applies to `c_o`.
- R3: The product equals the negacyclic product. Coefficient j is the sum of a_i·b_l over i+l = j, minus the sum over i+l = j+512, taken mod 12289. This holds for every operand pattern, including the wrap of x^512 to −1.
- R4: Every product coefficient lies in [0, 12289), provided that the operand coefficients lie in that range.
- R5: The product stream occupies 64 consecutive cycles with `c_vld_o` high. Groups appear in the order t = 0..63.
- R6: `done_o` is high for exactly one cycle per multiplication, together with the group t = 63.
- R7: While a multiplication is in progress, a high `start` is ignored. It does not change the result, and it produces no additional product stream.
- R8: The first product group appears 146 clock edges after the edge that accepts `start`.
- R9: A new multiplication is accepted from the cycle in which `done_o` is high. Its result does not depend on the previous operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Accept strobe; marks operand group 0 |
| a_i | input | 8x14 | First operand group, lane k = coefficient 8t+k |
| b_i | input | 8x14 | Second operand group, same lane mapping |
| c_o | output | 8x14 | Product group, same lane mapping |
| c_vld_o | output | 1 | Product group valid |
| done_o | output | 1 | Last product group of a multiplication |

## Verification
The bound checker watches the framing on every cycle. It confirms that `done_o` only comes with a valid group, on the 64th beat and for a single cycle. It also confirms that the product stream has no gaps, that the busy state ends only at `done_o`, and that every output coefficient is reduced below q. Arithmetic correctness cannot be checked cycle by cycle. The bench scenarios compare whole products against a schoolbook negacyclic product. The patterns are a monomial pair that wraps to −1, the unit polynomial, full-range random operands, and operand sets driven back to back. The same scenarios measure the latency and show that a stray `start` leaves both the result and the number of output frames unchanged.

// File: rtl/ntt_pkg.sv
package ntt_pkg;
  localparam int unsigned N     = 512;
  localparam int unsigned LANES = 8;
  localparam int unsigned Q     = 12289;
  localparam int unsigned PSI   = 49;            // primitive 2N-th root of unity mod Q
  localparam int unsigned CW    = $clog2(Q);
  localparam int unsigned LOGN  = $clog2(N);
  localparam int unsigned DEPTH = N / LANES;     // groups per polynomial
  localparam int unsigned TW    = $clog2(DEPTH);
  localparam logic [CW:0] QX    = (CW+1)'(Q);

  typedef logic [CW-1:0] coef_t;
  typedef logic [LANES-1:0][CW-1:0] row_t;

  function automatic int unsigned pow_mod(int unsigned b, int unsigned e);
    longint unsigned r, x;
    r = 1;
    x = longint'(b % Q);
    for (int i = 0; i < 32; i++) begin
      if (e[i]) r = (r * x) % Q;
      x = (x * x) % Q;
    end
    return r[31:0];
  endfunction

  function automatic int unsigned bit_rev(int unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < LOGN; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  // twiddle for butterflies of span len in block blk; inverse uses the reciprocal
  function automatic int unsigned twiddle(int unsigned len, int unsigned blk, bit inv);
    int unsigned e;
    e = bit_rev(N / (2 * len) + blk);
    if (inv) e = (2 * N - e) % (2 * N);
    return pow_mod(PSI, e);
  endfunction

  localparam int unsigned NINV = pow_mod(N, Q - 2);

  function automatic coef_t add_q(coef_t x, coef_t y);
    logic [CW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= QX) s = s - QX;
    return s[CW-1:0];
  endfunction

  function automatic coef_t sub_q(coef_t x, coef_t y);
    logic [CW:0] s;
    s = {1'b0, x} + QX - {1'b0, y};
    if (s >= QX) s = s - QX;
    return s[CW-1:0];
  endfunction

  function automatic coef_t mul_q(coef_t x, coef_t y);
    logic [2*CW-1:0] p;
    p = (2*CW)'(x) * (2*CW)'(y);
    return CW'(p % (2*CW)'(Q));
  endfunction
endpackage

// File: rtl/ntt_bfly.sv
module ntt_bfly import ntt_pkg::*; #(
  parameter bit INV = 1'b0
) (
  input  coef_t x,
  input  coef_t y,
  input  coef_t w,
  output coef_t u,
  output coef_t v
);
  if (!INV) begin : g_ct
    coef_t m;
    assign m = mul_q(w, y);
    assign u = add_q(x, m);
    assign v = sub_q(x, m);
  end else begin : g_gs
    assign u = add_q(x, y);
    assign v = mul_q(sub_q(x, y), w);
  end
endmodule

// File: rtl/ntt_sdf_stage.sv
// Butterflies of span L >= LANES: partners share a lane, D = L/LANES groups apart.
module ntt_sdf_stage import ntt_pkg::*; #(
  parameter int unsigned L   = 8,
  parameter bit          INV = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  row_t d_i,
  output logic vld_o,
  output row_t d_o
);
  localparam int unsigned D  = L / LANES;
  localparam int unsigned DB = $clog2(D);

  logic [TW-1:0] cnt;
  logic [D:0]    vsh;
  logic          second;
  coef_t         w;
  coef_t         rom [DEPTH];

  initial begin
    for (int unsigned t = 0; t < DEPTH; t++)
      rom[t] = coef_t'(twiddle(L, (LANES * t) / (2 * L), INV));
  end

  assign w      = rom[cnt];
  assign second = cnt[DB];
  assign vld_o  = vsh[D];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      vsh <= '0;
    end else begin
      cnt <= vld_i ? cnt + 1'b1 : '0;
      vsh <= {vsh[D-1:0], vld_i};
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    coef_t dl [D];
    coef_t u, v, oq;
    ntt_bfly #(.INV(INV)) u_bf (.x(dl[D-1]), .y(d_i[k]), .w(w), .u(u), .v(v));
    always_ff @(posedge clk) begin
      dl[0] <= second ? v : d_i[k];
      for (int i = 1; i < D; i++) dl[i] <= dl[i-1];
      oq <= second ? u : dl[D-1];
    end
    assign d_o[k] = oq;
  end
endmodule

// File: rtl/ntt_xl_stage.sv
// Butterflies of span L < LANES: partners arrive in the same cycle on lanes k and k+L.
module ntt_xl_stage import ntt_pkg::*; #(
  parameter int unsigned L   = 1,
  parameter bit          INV = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  row_t d_i,
  output logic vld_o,
  output row_t d_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      vld_o <= 1'b0;
    end else begin
      cnt   <= vld_i ? cnt + 1'b1 : '0;
      vld_o <= vld_i;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if ((k & L) == 0) begin : g_bf
      coef_t rom [DEPTH];
      coef_t u, v, uq, vq;
      initial begin
        for (int unsigned t = 0; t < DEPTH; t++)
          rom[t] = coef_t'(twiddle(L, (LANES * t + k) / (2 * L), INV));
      end
      ntt_bfly #(.INV(INV)) u_bf (.x(d_i[k]), .y(d_i[k+L]), .w(rom[cnt]), .u(u), .v(v));
      always_ff @(posedge clk) begin
        uq <= u;
        vq <= v;
      end
      assign d_o[k]   = uq;
      assign d_o[k+L] = vq;
    end
  end
endmodule

// File: rtl/ntt_xform.sv
// Full transform: forward spans N/2..1 (natural in, bit-reversed out),
// inverse spans 1..N/2 (bit-reversed in, natural out, unscaled).
module ntt_xform import ntt_pkg::*; #(
  parameter bit INV = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  row_t d_i,
  output logic vld_o,
  output row_t d_o
);
  logic vs [LOGN+1];
  row_t ds [LOGN+1];

  assign vs[0] = vld_i;
  assign ds[0] = d_i;

  for (genvar s = 0; s < LOGN; s++) begin : g_stage
    localparam int unsigned L = INV ? (1 << s) : ((N / 2) >> s);
    if (L >= LANES) begin : g_sdf
      ntt_sdf_stage #(.L(L), .INV(INV)) u_st (
        .clk(clk), .rst(rst), .vld_i(vs[s]), .d_i(ds[s]), .vld_o(vs[s+1]), .d_o(ds[s+1]));
    end else begin : g_xl
      ntt_xl_stage #(.L(L), .INV(INV)) u_st (
        .clk(clk), .rst(rst), .vld_i(vs[s]), .d_i(ds[s]), .vld_o(vs[s+1]), .d_o(ds[s+1]));
    end
  end

  assign vld_o = vs[LOGN];
  assign d_o   = ds[LOGN];
endmodule

// File: rtl/ntt_polymul.sv
module ntt_polymul import ntt_pkg::*; (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [LANES-1:0][CW-1:0]  a_i,
  input  logic [LANES-1:0][CW-1:0]  b_i,
  output logic [LANES-1:0][CW-1:0]  c_o,
  output logic                      c_vld_o,
  output logic                      done_o
);
  localparam coef_t SCALE = coef_t'(NINV);
  localparam logic [TW-1:0] LAST = TW'(DEPTH - 1);

  logic          busy, ld_act, in_vld, acc, pm_vld;
  logic [TW-1:0] ld_cnt, out_cnt;
  row_t          a_q, b_q, fa, fb, pm_q, iv;
  logic          fa_vld, fb_vld, iv_vld;

  assign acc = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ld_act  <= 1'b0;
      ld_cnt  <= '0;
      in_vld  <= 1'b0;
      pm_vld  <= 1'b0;
      out_cnt <= '0;
      c_vld_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      in_vld <= acc || ld_act;
      if (acc) begin
        busy   <= 1'b1;
        ld_act <= 1'b1;
        ld_cnt <= TW'(1);
      end else if (ld_act) begin
        ld_cnt <= ld_cnt + 1'b1;
        if (ld_cnt == LAST) ld_act <= 1'b0;
      end
      pm_vld  <= fa_vld && fb_vld;
      c_vld_o <= iv_vld;
      done_o  <= iv_vld && (out_cnt == LAST);
      if (iv_vld) begin
        out_cnt <= out_cnt + 1'b1;
        if (out_cnt == LAST) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    a_q <= a_i;
    b_q <= b_i;
    for (int k = 0; k < LANES; k++) begin
      pm_q[k] <= mul_q(fa[k], fb[k]);
      c_o[k]  <= mul_q(iv[k], SCALE);
    end
  end

  ntt_xform #(.INV(1'b0)) u_fwd_a (
    .clk(clk), .rst(rst), .vld_i(in_vld), .d_i(a_q), .vld_o(fa_vld), .d_o(fa));
  ntt_xform #(.INV(1'b0)) u_fwd_b (
    .clk(clk), .rst(rst), .vld_i(in_vld), .d_i(b_q), .vld_o(fb_vld), .d_o(fb));
  ntt_xform #(.INV(1'b1)) u_inv (
    .clk(clk), .rst(rst), .vld_i(pm_vld), .d_i(pm_q), .vld_o(iv_vld), .d_o(iv));
endmodule

// File: rtl/ntt_polymul_chk.sv
module ntt_polymul_chk import ntt_pkg::*; (
  input logic clk,
  input logic rst,
  input logic busy,
  input row_t c_o,
  input logic c_vld_o,
  input logic done_o
);
  logic [TW-1:0] beat;

  always_ff @(posedge clk) begin
    if (rst) beat <= '0;
    else if (c_vld_o) beat <= beat + 1'b1;
  end

  function automatic bit row_ok(row_t r);
    for (int k = 0; k < LANES; k++)
      if (r[k] >= CW'(Q)) return 1'b0;
    return 1'b1;
  endfunction

  // R6
  done_with_beat_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> c_vld_o);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);
  // R5
  done_last_beat_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> (beat == TW'(DEPTH - 1)));
  // R5
  stream_gap_chk: assert property (@(posedge clk) disable iff (rst) (c_vld_o && !done_o) |=> c_vld_o);
  // R4
  coef_range_chk: assert property (@(posedge clk) disable iff (rst) c_vld_o |-> row_ok(c_o));
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done_o);
  // R7
  out_in_run_chk: assert property (@(posedge clk) disable iff (rst) (c_vld_o && !done_o) |-> busy);
endmodule

bind ntt_polymul ntt_polymul_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .c_o(c_o), .c_vld_o(c_vld_o), .done_o(done_o));

// File: tb/sim_ntt_polymul.sv
module sim_ntt_polymul;
  import ntt_pkg::*;

  localparam int CLK_P = 10;
  localparam int LAT   = 146;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  row_t a_i = '0;
  row_t b_i = '0;
  row_t c_o;
  logic c_vld_o, done_o;

  ntt_polymul u0 (.clk(clk), .rst(rst), .start(start), .a_i(a_i), .b_i(b_i),
                  .c_o(c_o), .c_vld_o(c_vld_o), .done_o(done_o));

  always #(CLK_P/2) clk = ~clk;

  int unsigned pa [N];
  int unsigned pb [N];
  int unsigned ref_c [N];
  int unsigned got_c [N];
  int n_run = 0, n_fail = 0;
  int pcyc = 0, start_pcyc = 0, first_pcyc = 0;
  int obeat = 0, frames = 0, done_cnt = 0, done_bad = 0, gap_bad = 0;
  int unsigned rng = 32'h1234_5678;

  always @(posedge clk) pcyc++;

  always @(negedge clk) begin
    if (!rst) begin
      if (c_vld_o) begin
        for (int k = 0; k < LANES; k++) got_c[LANES*obeat+k] = int'(c_o[k]);
        if (obeat == 0) first_pcyc = pcyc;
        if (done_o != (obeat == DEPTH-1)) done_bad++;
        obeat++;
        if (obeat == DEPTH) begin obeat = 0; frames++; end
      end else if (obeat != 0) gap_bad++;
      if (done_o) done_cnt++;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd_coef();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng % Q;
  endfunction

  task automatic calc_ref();
    longint acc [N];
    for (int j = 0; j < N; j++) acc[j] = 0;
    for (int i = 0; i < N; i++)
      for (int l = 0; l < N; l++) begin
        longint p;
        p = (longint'(pa[i]) * longint'(pb[l])) % Q;
        if (i + l < N) acc[i+l] += p;
        else acc[i+l-N] += Q - p;
      end
    for (int j = 0; j < N; j++) ref_c[j] = int'(acc[j] % Q);
  endtask

  // stray: extra beat on which start is also held high (-1 for none)
  task automatic drive_ops(int stray);
    for (int t = 0; t < DEPTH; t++) begin
      @(negedge clk);
      if (t == 0) start_pcyc = pcyc;
      start = (t == 0) || (t == stray);
      for (int k = 0; k < LANES; k++) begin
        a_i[k] = coef_t'(pa[LANES*t+k]);
        b_i[k] = coef_t'(pb[LANES*t+k]);
      end
    end
    @(negedge clk);
    start = 1'b0; a_i = '0; b_i = '0;
  endtask

  task automatic wait_frame(int f0);
    int guard = 0;
    while (frames == f0 && guard < 3000) begin @(negedge clk); guard++; end
  endtask

  task automatic run_and_check(string tag, int stray, bit junk_start);
    int f0, d0, mism, bad_idx, over;
    f0 = frames; d0 = done_cnt;
    calc_ref();
    drive_ops(stray);
    if (junk_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      for (int k = 0; k < LANES; k++) begin a_i[k] = coef_t'(k + 1); b_i[k] = coef_t'(7); end
      @(negedge clk);
      start = 1'b0; a_i = '0; b_i = '0;
    end
    wait_frame(f0);
    mism = 0; bad_idx = -1; over = 0;
    for (int j = 0; j < N; j++) begin
      if (got_c[j] != ref_c[j]) begin mism++; if (bad_idx < 0) bad_idx = j; end
      if (got_c[j] >= Q) over++;
    end
    if (bad_idx < 0) check(1'b1, "R3", tag, 0, 0);
    else check(1'b0, "R3", {tag, " coef mismatch"}, got_c[bad_idx], ref_c[bad_idx]);
    check(over == 0, "R4", {tag, " out-of-range coefs"}, over, 0);
    check(frames == f0 + 1, "R5", {tag, " frames"}, frames - f0, 1);
    check(gap_bad == 0, "R5", {tag, " stream gaps"}, gap_bad, 0);
    check(done_cnt == d0 + 1 && done_bad == 0, "R6", {tag, " done pulses"}, done_cnt - d0, 1);
    check(first_pcyc - start_pcyc - 1 == LAT, "R8", {tag, " latency"},
          first_pcyc - start_pcyc - 1, LAT);
  endtask

  task automatic t_reset();
    int seen = 0;
    check(c_vld_o == 1'b0, "R1", "c_vld_o after reset", c_vld_o, 0);
    check(done_o == 1'b0, "R1", "done_o after reset", done_o, 0);
    repeat (30) begin @(negedge clk); if (c_vld_o || done_o) seen++; end
    check(seen == 0, "R1", "idle outputs", seen, 0);
  endtask

  task automatic t_wrap();   // x * x^511 = x^512 = -1 (R2 lane mapping, R3 wrap)
    for (int j = 0; j < N; j++) begin pa[j] = 0; pb[j] = 0; end
    pa[1] = 1; pb[N-1] = 1;
    run_and_check("wrap", -1, 1'b0);
    check(got_c[0] == Q - 1, "R2", "wrap coef 0", got_c[0], Q - 1);
  endtask

  task automatic t_unit();   // 1 * b = b
    for (int j = 0; j < N; j++) begin pa[j] = (j == 0); pb[j] = rnd_coef(); end
    run_and_check("unit", -1, 1'b0);
    check(got_c[N-1] == pb[N-1], "R2", "unit last coef", got_c[N-1], pb[N-1]);
  endtask

  task automatic t_random();
    for (int j = 0; j < N; j++) begin pa[j] = rnd_coef(); pb[j] = rnd_coef(); end
    pa[0] = Q - 1; pb[N-1] = Q - 1; pa[N-1] = Q - 1;
    run_and_check("random", -1, 1'b0);
  endtask

  task automatic t_busy_start();  // R7
    int f1;
    for (int j = 0; j < N; j++) begin pa[j] = rnd_coef(); pb[j] = rnd_coef(); end
    run_and_check("busy-start R7", 10, 1'b1);
    f1 = frames;
    repeat (400) @(negedge clk);
    check(frames == f1, "R7", "extra frames after stray start", frames - f1, 0);
  endtask

  task automatic t_back2back();   // R9
    for (int j = 0; j < N; j++) begin pa[j] = Q - 1 - (j % 5); pb[j] = rnd_coef(); end
    run_and_check("b2b-1 R9", -1, 1'b0);
    for (int j = 0; j < N; j++) begin pa[j] = rnd_coef(); pb[j] = (j < 3) ? 1 : 0; end
    run_and_check("b2b-2 R9", -1, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wrap();
    t_unit();
    t_random();
    t_busy_start();
    t_back2back();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule